// File: doc/BRIEF.md
# Banked External Memory Wait-State Controller

This block stands between a processor's two internal memory request ports (a data space and a program space) and an external asynchronous memory bus. Each space is cut into banks by programmable start addresses: the data space has four banks over a 32-bit address, and the program space has two banks over a 24-bit address. For every access the block drives the active-low select of the matching bank, holds the address, the write data and the strobes on the external bus, and stretches the access by that bank's own wait-state count. A per-bank mode can let an external acknowledge input end the access early or stretch it.

The two spaces run on separate state machines, so a slow access on one side never stalls the other. The requester raises a one-cycle request and gets back a one-cycle done pulse. For a read, the captured read data is valid while done is high. The bank boundaries and per-bank timing come from a small configuration register file. A write to it that arrives while either side is busy is held and applied once both sides are idle.

Top module: `bank_wait_ctrl`

## Requirements
- R1: A data address selects the highest of banks 1 to 3 whose start address it equals or exceeds, and bank 0 otherwise. During the access, bit b of `dm_sel_n` is low for bank b. Exactly one bit is low while a strobe is active, and all bits are high when the data side is idle.
- R2: A program address selects bank 1 when it equals or exceeds the bank-1 start address, and bank 0 otherwise. Bit b of `pm_sel_n` is low during an access to bank b, exactly one bit is low while a strobe is active, and all bits are high when idle.
- R3: In mode 0 (count only), with a wait count W from 0 to 7, the access keeps select and strobe low for W+1 cycles. A request sampled at clock edge k gives a done pulse of exactly one cycle after edge k+W+1. With W=0 the access lasts a single cycle.
- R4: In mode 1 (acknowledge only), the access ends in the first access cycle in which the acknowledge input is high. The wait count is ignored.
- R5: In mode 2, the access ends in the first access cycle in which the count has expired and acknowledge is high, so the access lasts max(W+1, A) cycles, where A is the first access cycle with acknowledge high.
- R6: In mode 3, the access ends when the count has expired or acknowledge is high, whichever comes first, so the access lasts min(W+1, A) cycles.
- R7: Select, address, write data and strobes stay constant from the first access cycle to the last. A read drives the read strobe low, and a write drives the write strobe low with the write data on the bus. On a read, the bus data present in the last access cycle appears on the side's read-data output while done is high.
- R8: A data request and a program request sampled on the same edge both start at once, and each completes at its own latency.
- R9: The configuration register map is: address 0 to 2 hold the start addresses of data banks 1 to 3; address 3 holds the start of program bank 1; address 4 to 7 hold the timing of data banks 0 to 3; address 8 to 9 hold the timing of program banks 0 to 1. Timing bits [2:0] are the wait count and bits [4:3] are the mode. A write made while both sides are idle takes effect at that edge. A write made while either side is busy is held and takes effect on the first edge on which both sides are idle. An access starting on that same edge still uses the old values.
- R10: After reset all selects and strobes are high, both done outputs are low, every bank has wait count 7 in mode 0, the data bank starts are 0x4000_0000, 0x8000_0000 and 0xC000_0000, and the program bank-1 start is 0x80_0000.
- R11: A request raised while its side is busy is ignored. It does not change the ongoing access and does not produce a done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write value |
| d_req | input | 1 | Data-space request pulse |
| d_we | input | 1 | Data-space write (1) or read (0) |
| d_addr | input | 32 | Data-space address |
| d_wdata | input | 40 | Data-space write data |
| d_done | output | 1 | Data-space completion pulse |
| d_rdata | output | 40 | Data-space read data |
| p_req | input | 1 | Program-space request pulse |
| p_we | input | 1 | Program-space write (1) or read (0) |
| p_addr | input | 24 | Program-space address |
| p_wdata | input | 48 | Program-space write data |
| p_done | output | 1 | Program-space completion pulse |
| p_rdata | output | 48 | Program-space read data |
| dm_sel_n | output | 4 | Data bank selects, active low |
| dm_rd_n | output | 1 | Data read strobe, active low |
| dm_wr_n | output | 1 | Data write strobe, active low |
| dm_addr | output | 32 | Data bus address |
| dm_wdata | output | 40 | Data bus write data |
| dm_rdata | input | 40 | Data bus read data |
| dm_ack | input | 1 | Data bus acknowledge |
| pm_sel_n | output | 2 | Program bank selects, active low |
| pm_rd_n | output | 1 | Program read strobe, active low |
| pm_wr_n | output | 1 | Program write strobe, active low |
| pm_addr | output | 24 | Program bus address |
| pm_wdata | output | 48 | Program bus write data |
| pm_rdata | input | 48 | Program bus read data |
| pm_ack | input | 1 | Program bus acknowledge |

## Verification
A request sampled on edge k makes the selects and strobes appear after that edge. Done shows up after edge k+c, where c is W+1, A, max(W+1, A) or min(W+1, A) according to the mode. The bench numbers every rising edge and records k when it drives a request. At each falling edge it compares the edge count against k+c, so each result is read half a cycle after the edge that produced it. The acknowledge stimulus rises in access cycle A, counted by the bench from the selects. A deferred configuration write is judged by the latency of the next access, and that access is started one idle cycle after the blocking access has finished.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int WS_W = 3;

  typedef enum logic [1:0] {
    AM_COUNT  = 2'd0,
    AM_ACK    = 2'd1,
    AM_BOTH   = 2'd2,
    AM_EITHER = 2'd3
  } ack_mode_e;

  typedef struct packed {
    ack_mode_e         mode;
    logic [WS_W-1:0]   ws;
  } bank_timing_t;

  localparam int TIM_W = $bits(bank_timing_t);
endpackage

// File: rtl/bwc_bank_decode.sv
module bwc_bank_decode #(
  parameter int AW = 32,
  parameter int NB = 4,
  parameter int BW = $clog2(NB)
) (
  input  logic [AW-1:0]          addr,
  input  logic [NB-1:1][AW-1:0]  start,
  output logic [BW-1:0]          bank
);
  logic [NB-1:1] at_or_above;

  genvar gi;
  generate
    for (gi = 1; gi < NB; gi++) begin : g_cmp
      assign at_or_above[gi] = (addr >= start[gi]);
    end
  endgenerate

  // highest matching bank wins
  always_comb begin
    bank = '0;
    for (int i = 1; i < NB; i++) begin
      if (at_or_above[i]) bank = BW'(i);
    end
  end
endmodule

// File: rtl/bwc_cfg_regs.sv
module bwc_cfg_regs
  import bwc_pkg::*;
#(
  parameter int D_AW   = 32,
  parameter int P_AW   = 24,
  parameter int D_NB   = 4,
  parameter int P_NB   = 2,
  parameter int CFG_AW = 4,
  parameter int CFG_DW = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [CFG_DW-1:0]           cfg_wdata,
  input  logic                        d_idle,
  input  logic                        p_idle,
  output logic [D_NB-1:1][D_AW-1:0]   d_start,
  output logic [P_NB-1:1][P_AW-1:0]   p_start,
  output bank_timing_t [D_NB-1:0]     d_tim,
  output bank_timing_t [P_NB-1:0]     p_tim
);
  localparam int DS_BASE = 0;
  localparam int PS_BASE = DS_BASE + D_NB - 1;
  localparam int DT_BASE = PS_BASE + P_NB - 1;
  localparam int PT_BASE = DT_BASE + D_NB;
  localparam int D_SH    = D_AW - $clog2(D_NB);
  localparam int P_SH    = P_AW - $clog2(P_NB);

  logic              pend_v;
  logic [CFG_AW-1:0] pend_a;
  logic [CFG_DW-1:0] pend_d;
  logic              both_idle, direct;
  logic              app_v;
  logic [CFG_AW-1:0] app_a;
  logic [CFG_DW-1:0] app_d;

  assign both_idle = d_idle & p_idle;
  assign direct    = cfg_we & both_idle & ~pend_v;

  always_comb begin
    if (pend_v) begin
      app_v = both_idle;
      app_a = pend_a;
      app_d = pend_d;
    end else begin
      app_v = direct;
      app_a = cfg_addr;
      app_d = cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_d <= '0;
    end else if (cfg_we && !direct) begin
      pend_v <= 1'b1;
      pend_a <= cfg_addr;
      pend_d <= cfg_wdata;
    end else if (pend_v && both_idle) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i < D_NB; i++) d_start[i] <= D_AW'(i) << D_SH;
      for (int i = 1; i < P_NB; i++) p_start[i] <= P_AW'(i) << P_SH;
      for (int i = 0; i < D_NB; i++) d_tim[i] <= '{mode: AM_COUNT, ws: '1};
      for (int i = 0; i < P_NB; i++) p_tim[i] <= '{mode: AM_COUNT, ws: '1};
    end else if (app_v) begin
      for (int i = 1; i < D_NB; i++)
        if (app_a == CFG_AW'(DS_BASE + i - 1)) d_start[i] <= app_d[D_AW-1:0];
      for (int i = 1; i < P_NB; i++)
        if (app_a == CFG_AW'(PS_BASE + i - 1)) p_start[i] <= app_d[P_AW-1:0];
      for (int i = 0; i < D_NB; i++)
        if (app_a == CFG_AW'(DT_BASE + i)) d_tim[i] <= bank_timing_t'(app_d[TIM_W-1:0]);
      for (int i = 0; i < P_NB; i++)
        if (app_a == CFG_AW'(PT_BASE + i)) p_tim[i] <= bank_timing_t'(app_d[TIM_W-1:0]);
    end
  end
endmodule

// File: rtl/bwc_access_fsm.sv
module bwc_access_fsm
  import bwc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 40,
  parameter int NB = 4,
  parameter int BW = $clog2(NB)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic [BW-1:0]            bank,
  input  bank_timing_t [NB-1:0]    tim,
  input  logic                     ack,
  input  logic [DW-1:0]            bus_rdata,
  output logic [NB-1:0]            sel_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [AW-1:0]            bus_addr,
  output logic [DW-1:0]            bus_wdata,
  output logic                     done,
  output logic [DW-1:0]            rdata,
  output logic                     idle
);
  logic            busy, we_q, finish, cnt_zero;
  ack_mode_e       mode_q;
  logic [WS_W-1:0] cnt;
  bank_timing_t    cur;

  assign cur      = tim[bank];
  assign idle     = ~busy;
  assign cnt_zero = (cnt == '0);

  always_comb begin
    unique case (mode_q)
      AM_COUNT: finish = cnt_zero;
      AM_ACK:   finish = ack;
      AM_BOTH:  finish = cnt_zero & ack;
      default:  finish = cnt_zero | ack;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      we_q      <= 1'b0;
      mode_q    <= AM_COUNT;
      cnt       <= '0;
      sel_n     <= '1;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      bus_addr  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy      <= 1'b1;
          we_q      <= we;
          mode_q    <= cur.mode;
          cnt       <= cur.ws;
          sel_n     <= ~(NB'(1) << bank);
          rd_n      <= we;
          wr_n      <= ~we;
          bus_addr  <= addr;
          bus_wdata <= wdata;
        end
      end else if (finish) begin
        busy  <= 1'b0;
        sel_n <= '1;
        rd_n  <= 1'b1;
        wr_n  <= 1'b1;
        done  <= 1'b1;
        if (!we_q) rdata <= bus_rdata;
      end else if (!cnt_zero) begin
        cnt <= cnt - WS_W'(1);
      end
    end
  end
endmodule

// File: rtl/bank_wait_ctrl.sv
module bank_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int D_AW   = 32,
  parameter int D_DW   = 40,
  parameter int D_NB   = 4,
  parameter int P_AW   = 24,
  parameter int P_DW   = 48,
  parameter int P_NB   = 2,
  parameter int CFG_AW = 4,
  parameter int CFG_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              d_req,
  input  logic              d_we,
  input  logic [D_AW-1:0]   d_addr,
  input  logic [D_DW-1:0]   d_wdata,
  output logic              d_done,
  output logic [D_DW-1:0]   d_rdata,
  input  logic              p_req,
  input  logic              p_we,
  input  logic [P_AW-1:0]   p_addr,
  input  logic [P_DW-1:0]   p_wdata,
  output logic              p_done,
  output logic [P_DW-1:0]   p_rdata,
  output logic [D_NB-1:0]   dm_sel_n,
  output logic              dm_rd_n,
  output logic              dm_wr_n,
  output logic [D_AW-1:0]   dm_addr,
  output logic [D_DW-1:0]   dm_wdata,
  input  logic [D_DW-1:0]   dm_rdata,
  input  logic              dm_ack,
  output logic [P_NB-1:0]   pm_sel_n,
  output logic              pm_rd_n,
  output logic              pm_wr_n,
  output logic [P_AW-1:0]   pm_addr,
  output logic [P_DW-1:0]   pm_wdata,
  input  logic [P_DW-1:0]   pm_rdata,
  input  logic              pm_ack
);
  localparam int D_BW = $clog2(D_NB);
  localparam int P_BW = $clog2(P_NB);

  logic [D_NB-1:1][D_AW-1:0] d_start;
  logic [P_NB-1:1][P_AW-1:0] p_start;
  bank_timing_t [D_NB-1:0]   d_tim;
  bank_timing_t [P_NB-1:0]   p_tim;
  logic [D_BW-1:0]           d_bank;
  logic [P_BW-1:0]           p_bank;
  logic                      d_idle, p_idle;

  bwc_cfg_regs #(
    .D_AW(D_AW), .P_AW(P_AW), .D_NB(D_NB), .P_NB(P_NB),
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .d_idle(d_idle), .p_idle(p_idle),
    .d_start(d_start), .p_start(p_start), .d_tim(d_tim), .p_tim(p_tim)
  );

  bwc_bank_decode #(.AW(D_AW), .NB(D_NB), .BW(D_BW)) u_d_dec (
    .addr(d_addr), .start(d_start), .bank(d_bank)
  );

  bwc_bank_decode #(.AW(P_AW), .NB(P_NB), .BW(P_BW)) u_p_dec (
    .addr(p_addr), .start(p_start), .bank(p_bank)
  );

  bwc_access_fsm #(.AW(D_AW), .DW(D_DW), .NB(D_NB), .BW(D_BW)) u_d_fsm (
    .clk(clk), .rst(rst), .req(d_req), .we(d_we), .addr(d_addr),
    .wdata(d_wdata), .bank(d_bank), .tim(d_tim), .ack(dm_ack),
    .bus_rdata(dm_rdata), .sel_n(dm_sel_n), .rd_n(dm_rd_n), .wr_n(dm_wr_n),
    .bus_addr(dm_addr), .bus_wdata(dm_wdata), .done(d_done),
    .rdata(d_rdata), .idle(d_idle)
  );

  bwc_access_fsm #(.AW(P_AW), .DW(P_DW), .NB(P_NB), .BW(P_BW)) u_p_fsm (
    .clk(clk), .rst(rst), .req(p_req), .we(p_we), .addr(p_addr),
    .wdata(p_wdata), .bank(p_bank), .tim(p_tim), .ack(pm_ack),
    .bus_rdata(pm_rdata), .sel_n(pm_sel_n), .rd_n(pm_rd_n), .wr_n(pm_wr_n),
    .bus_addr(pm_addr), .bus_wdata(pm_wdata), .done(p_done),
    .rdata(p_rdata), .idle(p_idle)
  );
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
  parameter int D_NB = 4,
  parameter int P_NB = 2,
  parameter int D_AW = 32,
  parameter int P_AW = 24
) (
  input logic            clk,
  input logic            rst,
  input logic [D_NB-1:0] dm_sel_n,
  input logic            dm_rd_n,
  input logic            dm_wr_n,
  input logic [D_AW-1:0] dm_addr,
  input logic            d_done,
  input logic [P_NB-1:0] pm_sel_n,
  input logic            pm_rd_n,
  input logic            pm_wr_n,
  input logic [P_AW-1:0] pm_addr,
  input logic            p_done
);
  p_dsel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dm_sel_n));
  p_dstrobe_sel_r1: assert property (@(posedge clk) disable iff (rst)
    (!dm_rd_n || !dm_wr_n) |-> ($countones(~dm_sel_n) == 1));
  p_psel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~pm_sel_n));
  p_pstrobe_sel_r2: assert property (@(posedge clk) disable iff (rst)
    (!pm_rd_n || !pm_wr_n) |-> ($countones(~pm_sel_n) == 1));
  p_dhold_r7: assert property (@(posedge clk) disable iff (rst)
    (dm_sel_n != '1 && $past(dm_sel_n) != '1) |-> ($stable(dm_addr) && $stable(dm_sel_n)));
  p_phold_r7: assert property (@(posedge clk) disable iff (rst)
    (pm_sel_n != '1 && $past(pm_sel_n) != '1) |-> ($stable(pm_addr) && $stable(pm_sel_n)));
  p_ddone_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    d_done |=> !d_done);
  p_pdone_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    p_done |=> !p_done);
  p_ddone_end_r3: assert property (@(posedge clk) disable iff (rst)
    d_done |-> ($past(dm_sel_n) != '1 && dm_sel_n == '1));
  p_pdone_end_r3: assert property (@(posedge clk) disable iff (rst)
    p_done |-> ($past(pm_sel_n) != '1 && pm_sel_n == '1));
endmodule

bind bank_wait_ctrl bwc_checker #(
  .D_NB(D_NB), .P_NB(P_NB), .D_AW(D_AW), .P_AW(P_AW)
) u_chk (
  .clk(clk), .rst(rst),
  .dm_sel_n(dm_sel_n), .dm_rd_n(dm_rd_n), .dm_wr_n(dm_wr_n),
  .dm_addr(dm_addr), .d_done(d_done),
  .pm_sel_n(pm_sel_n), .pm_rd_n(pm_rd_n), .pm_wr_n(pm_wr_n),
  .pm_addr(pm_addr), .p_done(p_done)
);

// File: tb/sim_bank_wait_ctrl.sv
`timescale 1ns/1ps
module sim_bank_wait_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        d_req = 1'b0, d_we = 1'b0;
  logic [31:0] d_addr = '0;
  logic [39:0] d_wdata = '0;
  logic        d_done;
  logic [39:0] d_rdata;
  logic        p_req = 1'b0, p_we = 1'b0;
  logic [23:0] p_addr = '0;
  logic [47:0] p_wdata = '0;
  logic        p_done;
  logic [47:0] p_rdata;
  logic [3:0]  dm_sel_n;
  logic        dm_rd_n, dm_wr_n;
  logic [31:0] dm_addr;
  logic [39:0] dm_wdata, dm_rdata;
  logic        dm_ack = 1'b0;
  logic [1:0]  pm_sel_n;
  logic        pm_rd_n, pm_wr_n;
  logic [23:0] pm_addr;
  logic [47:0] pm_wdata, pm_rdata;
  logic        pm_ack = 1'b0;

  assign dm_rdata = {8'h3C, dm_addr};
  assign pm_rdata = {24'h5A5A5A, pm_addr};

  bank_wait_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_done(d_done), .d_rdata(d_rdata),
    .p_req(p_req), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_done(p_done), .p_rdata(p_rdata),
    .dm_sel_n(dm_sel_n), .dm_rd_n(dm_rd_n), .dm_wr_n(dm_wr_n), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .dm_ack(dm_ack),
    .pm_sel_n(pm_sel_n), .pm_rd_n(pm_rd_n), .pm_wr_n(pm_wr_n), .pm_addr(pm_addr),
    .pm_wdata(pm_wdata), .pm_rdata(pm_rdata), .pm_ack(pm_ack)
  );

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [47:0] wdata;
    int          bank;
    int          mode;
    int          lat;
    int          start;
  } item_t;

  item_t dq[$];
  item_t pq[$];

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench copy of the configuration
  logic [31:0] dst [4];
  logic [23:0] pst [2];
  int dws [4], dmd [4], pws [2], pmd [2];
  int d_ack_at = 1, p_ack_at = 1;
  int d_act = 0, p_act = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lat_of(int md, int w, int a);
    case (md)
      0: return w + 1;
      1: return a;
      2: return (w + 1 > a) ? w + 1 : a;
      default: return (w + 1 < a) ? w + 1 : a;
    endcase
  endfunction

  function automatic string mtag(int md);
    case (md)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic int dbank(logic [31:0] a);
    int b = 0;
    for (int i = 1; i < 4; i++) if (a >= dst[i]) b = i;
    return b;
  endfunction

  // acknowledge rises in access cycle number d_ack_at / p_ack_at
  always @(negedge clk) begin
    if (dm_sel_n != 4'hF) d_act = d_act + 1; else d_act = 0;
    dm_ack = (dm_sel_n != 4'hF) && (d_act >= d_ack_at);
    if (pm_sel_n != 2'h3) p_act = p_act + 1; else p_act = 0;
    pm_ack = (pm_sel_n != 2'h3) && (p_act >= p_ack_at);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    item_t it;
    if (!rst) begin
      if (dm_sel_n != 4'hF && dq.size() > 0) begin
        chk(~dm_sel_n == (4'b1 << dq[0].bank), "R1", "data select", ~dm_sel_n, 4'b1 << dq[0].bank);
        chk(dm_addr == dq[0].addr, "R7", "data addr held", dm_addr, dq[0].addr);
        if (dq[0].we)
          chk(!dm_wr_n && dm_rd_n && dm_wdata == dq[0].wdata[39:0], "R7", "data write bus",
              {dm_rd_n, dm_wr_n, dm_wdata}, {2'b10, dq[0].wdata[39:0]});
        else
          chk(!dm_rd_n && dm_wr_n, "R7", "data read strobe", {dm_rd_n, dm_wr_n}, 2'b01);
      end
      if (d_done) begin
        if (dq.size() == 0) chk(1'b0, "R11", "unexpected data done", 1, 0);
        else begin
          it = dq.pop_front();
          chk(cyc == it.start + it.lat, mtag(it.mode), "data done cycle", cyc, it.start + it.lat);
          if (!it.we) chk(d_rdata == {8'h3C, it.addr}, "R7", "data rdata", d_rdata, {8'h3C, it.addr});
        end
      end
      if (pm_sel_n != 2'h3 && pq.size() > 0) begin
        chk(~pm_sel_n == (2'b1 << pq[0].bank), "R2", "prog select", ~pm_sel_n, 2'b1 << pq[0].bank);
        chk(pm_addr == pq[0].addr[23:0], "R7", "prog addr held", pm_addr, pq[0].addr[23:0]);
        if (pq[0].we)
          chk(!pm_wr_n && pm_rd_n && pm_wdata == pq[0].wdata, "R7", "prog write bus",
              {pm_rd_n, pm_wr_n, pm_wdata}, {2'b10, pq[0].wdata});
        else
          chk(!pm_rd_n && pm_wr_n, "R7", "prog read strobe", {pm_rd_n, pm_wr_n}, 2'b01);
      end
      if (p_done) begin
        if (pq.size() == 0) chk(1'b0, "R11", "unexpected prog done", 1, 0);
        else begin
          it = pq.pop_front();
          chk(cyc == it.start + it.lat, mtag(it.mode), "prog done cycle", cyc, it.start + it.lat);
          if (!it.we) chk(p_rdata == {24'h5A5A5A, it.addr[23:0]}, "R7", "prog rdata",
                          p_rdata, {24'h5A5A5A, it.addr[23:0]});
        end
      end
    end
  end

  // called at a falling edge; R9 register encoding
  task automatic cfg_wr(int a, logic [31:0] v, bit upd);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = v;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    if (upd) begin
      if (a <= 2) dst[a+1] = v;
      else if (a == 3) pst[1] = v[23:0];
      else if (a <= 7) begin dws[a-4] = int'(v[2:0]); dmd[a-4] = int'(v[4:3]); end
      else begin pws[a-8] = int'(v[2:0]); pmd[a-8] = int'(v[4:3]); end
    end
  endtask

  task automatic push_d(bit we, logic [31:0] a, logic [39:0] wd, output int st);
    item_t it;
    it.we = we; it.addr = a; it.wdata = {8'h00, wd}; it.bank = dbank(a);
    it.mode = dmd[it.bank]; it.lat = lat_of(it.mode, dws[it.bank], d_ack_at);
    it.start = cyc + 1; st = it.start;
    dq.push_back(it);
  endtask

  task automatic do_data(bit we, logic [31:0] a, logic [39:0] wd, output int st, output int dn);
    push_d(we, a, wd, st);
    d_req = 1'b1; d_we = we; d_addr = a; d_wdata = wd;
    @(posedge clk); @(negedge clk);
    d_req = 1'b0;
    while (!d_done) @(negedge clk);
    dn = cyc;
  endtask

  task automatic do_prog(bit we, logic [23:0] a, logic [47:0] wd, output int st, output int dn);
    item_t it;
    it.we = we; it.addr = {8'h00, a}; it.wdata = wd; it.bank = (a >= pst[1]) ? 1 : 0;
    it.mode = pmd[it.bank]; it.lat = lat_of(it.mode, pws[it.bank], p_ack_at);
    it.start = cyc + 1; st = it.start;
    pq.push_back(it);
    p_req = 1'b1; p_we = we; p_addr = a; p_wdata = wd;
    @(posedge clk); @(negedge clk);
    p_req = 1'b0;
    while (!p_done) @(negedge clk);
    dn = cyc;
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "R3", "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0, e0, s1, e1;
    dst[0] = 32'h0; dst[1] = 32'h4000_0000; dst[2] = 32'h8000_0000; dst[3] = 32'hC000_0000;
    pst[0] = 24'h0; pst[1] = 24'h80_0000;
    for (int i = 0; i < 4; i++) begin dws[i] = 7; dmd[i] = 0; end
    for (int i = 0; i < 2; i++) begin pws[i] = 7; pmd[i] = 0; end

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(dm_sel_n == 4'hF && pm_sel_n == 2'h3, "R10", "reset selects", {dm_sel_n, pm_sel_n}, 6'h3F);
    chk(dm_rd_n && dm_wr_n && pm_rd_n && pm_wr_n, "R10", "reset strobes",
        {dm_rd_n, dm_wr_n, pm_rd_n, pm_wr_n}, 4'hF);
    chk(!d_done && !p_done, "R10", "reset done", {d_done, p_done}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R10 defaults: every bank 7 waits, default boundaries
    do_data(0, 32'hC000_0010, '0, s0, e0);
    chk(e0 - s0 == 8, "R10", "default data latency", e0 - s0, 8);
    do_prog(0, 24'h80_0004, '0, s0, e0);
    chk(e0 - s0 == 8, "R10", "default prog latency", e0 - s0, 8);
    do_data(0, 32'h3FFF_FFFF, '0, s0, e0);

    // R9 programming through the register map
    cfg_wr(0, 32'h0000_0100, 1);
    cfg_wr(1, 32'h0000_1000, 1);
    cfg_wr(2, 32'h8000_0000, 1);
    cfg_wr(3, 32'h0040_0000, 1);
    cfg_wr(4, 32'h00, 1);   // d bank0: 0 waits, count
    cfg_wr(5, 32'h03, 1);   // d bank1: 3 waits, count
    cfg_wr(6, 32'h0A, 1);   // d bank2: ack only
    cfg_wr(7, 32'h14, 1);   // d bank3: both, 4 waits
    cfg_wr(8, 32'h1A, 1);   // p bank0: either, 2 waits
    cfg_wr(9, 32'h00, 1);   // p bank1: 0 waits

    // R1 decode sweep incl. boundaries
    d_ack_at = 3;
    do_data(0, 32'h0000_00FF, '0, s0, e0);
    chk(e0 - s0 == 1, "R3", "zero-wait single cycle", e0 - s0, 1);
    do_data(0, 32'h0000_0100, '0, s0, e0);
    do_data(1, 32'h0000_0FFF, 40'hAB_CDEF_0123, s0, e0);
    do_data(0, 32'h0000_1000, '0, s0, e0);
    do_data(0, 32'h7FFF_FFFF, '0, s0, e0);
    do_data(1, 32'h8000_0000, 40'h12_3456_789A, s0, e0);
    do_data(0, 32'hFFFF_FFFF, '0, s0, e0);
    do_data(1, 32'h0000_0010, 40'hFF_0000_FFFF, s0, e0);

    // R2 program decode
    p_ack_at = 2;
    do_prog(0, 24'h3F_FFFF, '0, s0, e0);
    do_prog(0, 24'h40_0000, '0, s0, e0);
    do_prog(1, 24'hFF_FFFF, 48'hDEAD_BEEF_CAFE, s0, e0);
    do_prog(1, 24'h00_0000, 48'h0123_4567_89AB, s0, e0);

    // R4 ack only, R5 both, R6 either
    d_ack_at = 1; do_data(0, 32'h0000_2000, '0, s0, e0);
    chk(e0 - s0 == 1, "R4", "ack-only immediate", e0 - s0, 1);
    d_ack_at = 6; do_data(0, 32'h0000_2004, '0, s0, e0);
    chk(e0 - s0 == 6, "R4", "ack-only late", e0 - s0, 6);
    d_ack_at = 1; do_data(0, 32'h9000_0000, '0, s0, e0);
    chk(e0 - s0 == 5, "R5", "both, count last", e0 - s0, 5);
    d_ack_at = 8; do_data(0, 32'h9000_0004, '0, s0, e0);
    chk(e0 - s0 == 8, "R5", "both, ack last", e0 - s0, 8);
    p_ack_at = 1; do_prog(0, 24'h00_1000, '0, s0, e0);
    chk(e0 - s0 == 1, "R6", "either, ack first", e0 - s0, 1);
    p_ack_at = 9; do_prog(0, 24'h00_1004, '0, s0, e0);
    chk(e0 - s0 == 3, "R6", "either, count first", e0 - s0, 3);

    // R8 both sides in the same cycle
    d_ack_at = 3;
    fork
      do_data(0, 32'h0000_0104, '0, s0, e0);
      do_prog(0, 24'h3F_0000, '0, s1, e1);
    join
    chk(s0 == s1 && e0 - s0 == 4 && e1 - s1 == 3, "R8", "concurrent latencies",
        {16'(e0 - s0), 16'(e1 - s1)}, {16'd4, 16'd3});
    @(negedge clk);

    // R11 request while busy is ignored
    push_d(0, 32'h0000_0200, '0, s0);
    d_req = 1'b1; d_we = 1'b0; d_addr = 32'h0000_0200;
    @(posedge clk); @(negedge clk);
    d_addr = 32'h0000_0010; d_we = 1'b1;
    @(posedge clk); @(negedge clk);
    d_req = 1'b0;
    while (!d_done) @(negedge clk);
    chk(cyc - s0 == 4, "R11", "busy access latency", cyc - s0, 4);
    repeat (3) begin
      @(negedge clk);
      chk(!d_done && dm_sel_n == 4'hF, "R11", "no second access", {d_done, dm_sel_n}, 5'h0F);
    end

    // R9 write deferred while the program side is busy
    cfg_wr(4, 32'h02, 1);   // d bank0: 2 waits
    cfg_wr(8, 32'h07, 1);   // p bank0: 7 waits, count
    fork
      do_prog(0, 24'h00_0010, '0, s1, e1);
      begin
        @(negedge clk);
        cfg_wr(4, 32'h00, 0);
        do_data(0, 32'h0000_0020, '0, s0, e0);
      end
    join
    chk(e0 - s0 == 3, "R9", "held write not yet applied", e0 - s0, 3);
    dws[0] = 0;
    @(negedge clk);
    do_data(0, 32'h0000_0024, '0, s0, e0);
    chk(e0 - s0 == 1, "R9", "held write applied once idle", e0 - s0, 1);

    repeat (3) @(negedge clk);
    chk(dq.size() == 0 && pq.size() == 0, "R3", "all accesses completed",
        dq.size() + pq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule